// File: doc/BRIEF.md
# Multi-Source I2C Address Matcher

This block sits behind a byte-level I2C front end and decides, for the first byte after each START, whether the device answers. It compares the upper seven bits of that byte against five sources at once:
- the hardware address strapped on seven pins;
- a programmable broadcast address, with its own enable;
- three programmable group addresses, each with its own enable.

The lowest bit of the byte selects the direction, where 1 means read. The front end reports START, STOP and each completed byte as single-cycle pulses. The matcher answers with a registered acknowledge decision in the cycle after the byte.

The block also follows the general-call software reset. The sequence is address byte 00h, then data byte A5h, then data byte 5Ah. When the last byte is accepted, the block raises a one-cycle pulse that returns the register file to its power-up contents. An accepted address selects the device until the next STOP or START. The direction of that address is held for the register access logic.

Top module: `i2c_addr_matcher`

## Requirements
- R1: An address byte whose bits [7:1] equal `hw_addr_i` is acknowledged in either direction. After it, `sel_o` is 1 and `rd_o` equals bit 0 of that byte.
- R2: The broadcast address is acknowledged only when `allcall_en_i` is 1 and bit 0 of the byte is 0 (write). A read to it, or any access while it is disabled, gets a NACK (`ack_o`=0).
- R3: Group address k (`sub_addr_i[8k+7:8k]`) is acknowledged only when `sub_en_i[k]` is 1 and the byte is a write. Each enable affects only its own address.
- R4: Only bits [7:1] of each stored broadcast or group register are compared. Stored bit 0 has no effect on matching.
- R5: An address byte that matches no source gets a NACK and leaves `sel_o` at 0. After that, no byte produces `ack_valid_o` until the next START.
- R6: The address byte 00h gets an ACK and starts the reset sequence, even when `hw_addr_i` is 0. Data bytes A5h and then 5Ah each get an ACK. `soft_rst_o` is 1 for exactly one cycle, in the same cycle as the ACK of 5Ah.
- R7: In the reset sequence, a data byte other than the expected one gets a NACK and gives no reset. Every later byte before the next START also gets a NACK.
- R8: Each address byte gives exactly one `ack_valid_o` pulse, one cycle after `byte_valid_i`, however many sources match it.
- R9: STOP returns the block to idle, where `sel_o` is 0 and bytes produce no `ack_valid_o`. A START at any time opens a new address phase. A byte in the same cycle as START is ignored.
- R10: During and right after reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | START or repeated START seen (pulse) |
| stop_i | input | 1 | STOP seen (pulse) |
| byte_valid_i | input | 1 | A received byte is on `byte_i` (pulse) |
| byte_i | input | 8 | Received byte |
| hw_addr_i | input | 7 | Strapped hardware address |
| allcall_addr_i | input | 8 | Stored broadcast address register (bits [7:1] used) |
| allcall_en_i | input | 1 | Broadcast address enable |
| sub_addr_i | input | 24 | Three stored group address registers, group k in bits [8k+7:8k] |
| sub_en_i | input | 3 | Group address enables, bit k for group k |
| ack_valid_o | output | 1 | Acknowledge decision valid this cycle |
| ack_o | output | 1 | 1 = ACK, 0 = NACK |
| sel_o | output | 1 | Device addressed by a non-reset address |
| rd_o | output | 1 | Direction of the accepted address (1 = read) |
| soft_rst_o | output | 1 | Register-file reset pulse |

## Verification
Directed cases drive each source alone, with its enable on and then off and in both directions. This separates the enable gating from the write-only rule of the broadcast and group addresses. A case where the broadcast address equals the hardware address shows that a double match still gives a single ACK pulse. Stored registers with bit 0 set show that this bit is left out of the compare. Reset sequences with a correct, a wrong first and a wrong second data byte, and a 00h address with the hardware address at 0, tell the reset path apart from ordinary selection. Random transactions with freshly drawn registers and enables, biased toward hitting each source, are compared against a bench model of the acknowledge rule.

// File: rtl/i2c_match_pkg.sv
package i2c_match_pkg;
  localparam int ADDR_W = 7;
  localparam int BYTE_W = ADDR_W + 1;

  localparam logic [BYTE_W-1:0] GC_ADDR  = 8'h00;
  localparam logic [BYTE_W-1:0] RST_KEY1 = 8'hA5;
  localparam logic [BYTE_W-1:0] RST_KEY2 = 8'h5A;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_SEL,
    ST_REJ,
    ST_GC1,
    ST_GC2,
    ST_GCEND
  } match_state_e;

  // compare a 7-bit address with the upper bits of a stored 8-bit register
  function automatic logic addr_eq(input logic [ADDR_W-1:0] a,
                                   input logic [BYTE_W-1:0] stored);
    return a == stored[BYTE_W-1:1];
  endfunction
endpackage

// File: rtl/i2c_addr_compare.sv
module i2c_addr_compare
  import i2c_match_pkg::*;
#(
  parameter int NSUB = 3
) (
  input  logic [BYTE_W-1:0]      addr_byte_i,
  input  logic [ADDR_W-1:0]      hw_addr_i,
  input  logic [BYTE_W-1:0]      allcall_reg_i,
  input  logic                   allcall_en_i,
  input  logic [NSUB*BYTE_W-1:0] sub_regs_i,
  input  logic [NSUB-1:0]        sub_en_i,
  output logic                   gc_hit_o,
  output logic                   hw_hit_o,
  output logic                   grp_hit_o
);
  logic            is_write;
  logic            all_hit;
  logic [NSUB-1:0] sub_hit;

  assign is_write = ~addr_byte_i[0];

  generate
    for (genvar k = 0; k < NSUB; k++) begin : g_sub
      assign sub_hit[k] = sub_en_i[k] & is_write &
                          addr_eq(addr_byte_i[BYTE_W-1:1], sub_regs_i[k*BYTE_W +: BYTE_W]);
    end
  endgenerate

  assign all_hit   = allcall_en_i & is_write & addr_eq(addr_byte_i[BYTE_W-1:1], allcall_reg_i);
  assign gc_hit_o  = (addr_byte_i == GC_ADDR);
  assign hw_hit_o  = (addr_byte_i[BYTE_W-1:1] == hw_addr_i);
  assign grp_hit_o = all_hit | (|sub_hit);
endmodule

// File: rtl/i2c_match_seq.sv
module i2c_match_seq
  import i2c_match_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              byte_valid_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              gc_hit_i,
  input  logic              hw_hit_i,
  input  logic              grp_hit_i,
  output logic              ack_valid_o,
  output logic              ack_o,
  output logic              sel_o,
  output logic              rd_o,
  output logic              soft_rst_o
);
  match_state_e st_q, st_d;
  logic ackv_q, ackv_d, ack_q, ack_d, rd_q, rd_d, rst_q, rst_d;

  always_comb begin
    st_d   = st_q;
    ackv_d = 1'b0;
    ack_d  = 1'b0;
    rst_d  = 1'b0;
    rd_d   = rd_q;
    if (start_i) begin
      st_d = ST_ADDR;
    end else if (stop_i) begin
      st_d = ST_IDLE;
    end else if (byte_valid_i) begin
      case (st_q)
        ST_ADDR: begin
          ackv_d = 1'b1;
          if (gc_hit_i) begin
            ack_d = 1'b1;
            st_d  = ST_GC1;
          end else if (hw_hit_i | grp_hit_i) begin
            ack_d = 1'b1;
            rd_d  = byte_i[0];
            st_d  = ST_SEL;
          end else begin
            st_d = ST_REJ;
          end
        end
        ST_GC1: begin
          ackv_d = 1'b1;
          if (byte_i == RST_KEY1) begin
            ack_d = 1'b1;
            st_d  = ST_GC2;
          end else begin
            st_d = ST_GCEND;
          end
        end
        ST_GC2: begin
          ackv_d = 1'b1;
          st_d   = ST_GCEND;
          if (byte_i == RST_KEY2) begin
            ack_d = 1'b1;
            rst_d = 1'b1;
          end
        end
        ST_GCEND: ackv_d = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ackv_q <= 1'b0;
      ack_q  <= 1'b0;
      rd_q   <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      ackv_q <= ackv_d;
      ack_q  <= ack_d;
      rd_q   <= rd_d;
      rst_q  <= rst_d;
    end
  end

  assign ack_valid_o = ackv_q;
  assign ack_o       = ack_q;
  assign sel_o       = (st_q == ST_SEL);
  assign rd_o        = rd_q & (st_q == ST_SEL);
  assign soft_rst_o  = rst_q;
endmodule

// File: rtl/i2c_addr_matcher.sv
module i2c_addr_matcher
  import i2c_match_pkg::*;
#(
  parameter int NSUB = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic                   stop_i,
  input  logic                   byte_valid_i,
  input  logic [BYTE_W-1:0]      byte_i,
  input  logic [ADDR_W-1:0]      hw_addr_i,
  input  logic [BYTE_W-1:0]      allcall_addr_i,
  input  logic                   allcall_en_i,
  input  logic [NSUB*BYTE_W-1:0] sub_addr_i,
  input  logic [NSUB-1:0]        sub_en_i,
  output logic                   ack_valid_o,
  output logic                   ack_o,
  output logic                   sel_o,
  output logic                   rd_o,
  output logic                   soft_rst_o
);
  // named decode events, also observed by the checker
  logic hit_gc, hit_hw, hit_grp;

  i2c_addr_compare #(.NSUB(NSUB)) u_cmp (
    .addr_byte_i  (byte_i),
    .hw_addr_i    (hw_addr_i),
    .allcall_reg_i(allcall_addr_i),
    .allcall_en_i (allcall_en_i),
    .sub_regs_i   (sub_addr_i),
    .sub_en_i     (sub_en_i),
    .gc_hit_o     (hit_gc),
    .hw_hit_o     (hit_hw),
    .grp_hit_o    (hit_grp)
  );

  i2c_match_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .stop_i      (stop_i),
    .byte_valid_i(byte_valid_i),
    .byte_i      (byte_i),
    .gc_hit_i    (hit_gc),
    .hw_hit_i    (hit_hw),
    .grp_hit_i   (hit_grp),
    .ack_valid_o (ack_valid_o),
    .ack_o       (ack_o),
    .sel_o       (sel_o),
    .rd_o        (rd_o),
    .soft_rst_o  (soft_rst_o)
  );
endmodule

// File: rtl/i2c_addr_matcher_chk.sv
module i2c_addr_matcher_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       stop_i,
  input logic       byte_valid_i,
  input logic [7:0] byte_i,
  input logic [6:0] hw_addr_i,
  input logic       hit_gc,
  input logic       ack_valid_o,
  input logic       ack_o,
  input logic       sel_o,
  input logic       rd_o,
  input logic       soft_rst_o
);
  assert_ack_timing_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid_o |-> $past(byte_valid_i));

  assert_rst_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_o |=> !soft_rst_o);

  assert_rst_acked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_o |-> (ack_valid_o && ack_o && $past(byte_i) == 8'h5A));

  assert_sel_acked_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_o) |-> (ack_valid_o && ack_o));

  // reads are only granted through the hardware address (R2, R3)
  assert_read_hw_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sel_o) && rd_o) |-> ($past(byte_i[7:1]) == $past(hw_addr_i)));

  assert_gc_not_sel_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid_i && hit_gc && !start_i && !stop_i) |=> !$rose(sel_o));

  assert_stop_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !start_i) |=> (!sel_o && !ack_valid_o && !soft_rst_o));
endmodule

bind i2c_addr_matcher i2c_addr_matcher_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .stop_i      (stop_i),
  .byte_valid_i(byte_valid_i),
  .byte_i      (byte_i),
  .hw_addr_i   (hw_addr_i),
  .hit_gc      (hit_gc),
  .ack_valid_o (ack_valid_o),
  .ack_o       (ack_o),
  .sel_o       (sel_o),
  .rd_o        (rd_o),
  .soft_rst_o  (soft_rst_o)
);

// File: tb/i2c_addr_matcher_bench.sv
module i2c_addr_matcher_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, stop_i = 1'b0, byte_valid_i = 1'b0;
  logic [7:0]  byte_i = '0;
  logic [6:0]  hw_addr_i = 7'h15;
  logic [7:0]  allcall_addr_i = 8'hE0;
  logic        allcall_en_i = 1'b1;
  logic [23:0] sub_addr_i = {8'hE8, 8'hE4, 8'hE2};
  logic [2:0]  sub_en_i = 3'b000;
  logic        ack_valid_o, ack_o, sel_o, rd_o, soft_rst_o;
  int          n_chk = 0, n_err = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  i2c_addr_matcher u_i2c_addr_matcher (.*);

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_start();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic do_stop();
    @(negedge clk); stop_i = 1'b1;
    @(negedge clk); stop_i = 1'b0;
  endtask

  // drive one byte; on return the decision for it is on the outputs
  task automatic send(input logic [7:0] b);
    @(negedge clk); byte_i = b; byte_valid_i = 1'b1;
    @(negedge clk); byte_valid_i = 1'b0;
  endtask

  // bench model of the acknowledge rule for an address byte
  function automatic bit model_ack(input logic [7:0] b);
    logic [7:0] grp[4];
    bit         en[4];
    grp[0] = allcall_addr_i; en[0] = allcall_en_i;
    for (int i = 0; i < 3; i++) begin
      grp[i+1] = sub_addr_i[i*8 +: 8];
      en[i+1]  = sub_en_i[i];
    end
    if (b == 8'h00) return 1'b1;
    if (b[7:1] == hw_addr_i) return 1'b1;
    if (b[0]) return 1'b0;
    for (int i = 0; i < 4; i++)
      if (en[i] && (grp[i] >> 1) == (b >> 1)) return 1'b1;
    return 1'b0;
  endfunction

  task automatic addr_case(input string req, input logic [7:0] b, input bit exp_ack);
    do_start();
    send(b);
    check(req, ack_valid_o, 1);
    check(req, ack_o, exp_ack);
    check(req, sel_o, exp_ack && b != 8'h00);
    if (exp_ack && b != 8'h00) check(req, rd_o, b[0]);
    do_stop();
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10", {ack_valid_o, ack_o, sel_o, rd_o, soft_rst_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10", {ack_valid_o, ack_o, sel_o, rd_o, soft_rst_o}, 0);

    // R1 hardware address, both directions
    addr_case("R1", {7'h15, 1'b0}, 1);
    addr_case("R1", {7'h15, 1'b1}, 1);
    // R2 broadcast address: write ok, read refused, disabled refused
    addr_case("R2", 8'hE0, 1);
    addr_case("R2", 8'hE1, 0);
    allcall_en_i = 1'b0;
    addr_case("R2", 8'hE0, 0);
    allcall_en_i = 1'b1;
    // R3 each group address with its own enable
    addr_case("R3", 8'hE4, 0);
    sub_en_i = 3'b010;
    addr_case("R3", 8'hE4, 1);
    addr_case("R3", 8'hE5, 0);
    addr_case("R3", 8'hE2, 0);
    sub_en_i = 3'b101;
    addr_case("R3", 8'hE2, 1);
    addr_case("R3", 8'hE8, 1);
    addr_case("R3", 8'hE4, 0);
    // R4 stored bit 0 ignored
    sub_addr_i[7:0] = 8'h93;
    addr_case("R4", 8'h92, 1);
    allcall_addr_i = 8'hC1;
    addr_case("R4", 8'hC0, 1);
    // R5 miss, then silence until START
    do_start();
    send(8'h40);
    check("R5", ack_valid_o, 1);
    check("R5", ack_o, 0);
    check("R5", sel_o, 0);
    send(8'h15 << 1);
    check("R5", ack_valid_o, 0);
    do_stop();
    // R8 double match: broadcast equals hardware address
    allcall_addr_i = {7'h15, 1'b0};
    do_start();
    @(negedge clk); byte_i = {7'h15, 1'b0}; byte_valid_i = 1'b1;
    @(negedge clk); byte_valid_i = 1'b0;
    check("R8", {ack_valid_o, ack_o}, 2'b11);
    @(negedge clk);
    check("R8", ack_valid_o, 0);
    check("R8", sel_o, 1);
    do_stop();
    check("R9", sel_o, 0);
    send(8'h2A);
    check("R9", ack_valid_o, 0);
    // R9 repeated start while selected; byte together with START ignored
    do_start();
    send(8'h2B);
    check("R9", rd_o, 1);
    @(negedge clk); start_i = 1'b1; byte_valid_i = 1'b1; byte_i = 8'h2A;
    @(negedge clk); start_i = 1'b0; byte_valid_i = 1'b0;
    check("R9", ack_valid_o, 0);
    check("R9", sel_o, 0);
    send(8'h2A);
    check("R9", {ack_valid_o, ack_o, sel_o, rd_o}, 4'b1110);
    do_stop();
    // R6 reset sequence, with hardware address 0 to test precedence
    hw_addr_i = 7'h00;
    do_start();
    send(8'h00);
    check("R6", {ack_valid_o, ack_o, sel_o}, 3'b110);
    send(8'hA5);
    check("R6", {ack_o, soft_rst_o}, 2'b10);
    send(8'h5A);
    check("R6", {ack_valid_o, ack_o, soft_rst_o}, 3'b111);
    @(negedge clk);
    check("R6", soft_rst_o, 0);
    do_stop();
    hw_addr_i = 7'h15;
    // R7 wrong first key, wrong second key
    do_start();
    send(8'h00);
    send(8'hA6);
    check("R7", {ack_valid_o, ack_o, soft_rst_o}, 3'b100);
    send(8'h5A);
    check("R7", {ack_valid_o, ack_o, soft_rst_o}, 3'b100);
    do_stop();
    do_start();
    send(8'h00);
    send(8'hA5);
    send(8'h5B);
    check("R7", {ack_valid_o, ack_o, soft_rst_o}, 3'b100);
    do_stop();

    // random transactions
    for (int it = 0; it < 300; it++) begin
      logic [7:0] a, d;
      bit         exp;
      hw_addr_i      = 7'($urandom);
      allcall_addr_i = 8'($urandom);
      allcall_en_i   = 1'($urandom);
      sub_addr_i     = 24'($urandom);
      sub_en_i       = 3'($urandom);
      case ($urandom % 6)
        0: a = {hw_addr_i, 1'($urandom)};
        1: a = {allcall_addr_i[7:1], 1'($urandom)};
        2, 3, 4: a = {sub_addr_i[($urandom % 3)*8 + 1 +: 7], 1'($urandom)};
        default: a = 8'($urandom % 4);
      endcase
      d   = ($urandom % 2) ? 8'hA5 : 8'($urandom);
      exp = model_ack(a);
      do_start();
      send(a);
      check("R1 R2 R3 random", {ack_valid_o, ack_o}, {1'b1, exp});
      check("R5 random", sel_o, exp && a != 8'h00);
      if (exp && a != 8'h00) check("R1 random", rd_o, a[0]);
      send(d);
      if (a == 8'h00) check("R6 random", {ack_valid_o, ack_o}, {1'b1, d == 8'hA5});
      else check("R5 random", ack_valid_o, 0);
      do_stop();
      check("R9 random", sel_o, 0);
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule